// File: doc/BRIEF.md
# Hash-Indexed Flow Lookup Stage

This block is the fast path of a packet pipeline. An upstream parser hands it one metadata record per packet, made of a precomputed header hash, the flow key and the packet length. The hash selects one slot of a direct-mapped table. If the slot is valid and holds the same key, the packet is a hit. A hit increments that flow's packet and byte counters and leaves on the hit output with the stored action code. Any other packet is a miss and leaves unchanged on the miss output, which feeds a slow-path rule classifier.

The classifier installs the entry for a new flow through a strobe port, so that later packets of that flow take the fast path. A host-side port writes or invalidates entries, for example to preload the table before traffic starts. It also reads any slot's contents and counters with a fixed one-cycle latency, without stalling lookups.

The control is built from three named state machines. The input stage has states EMPTY and FULL, with transitions load (EMPTY to FULL), refill (FULL to FULL) and drain (FULL to EMPTY). The result stage has states IDLE, HIT and MISS: it moves to HIT or MISS when it takes a record, and returns to IDLE when its output is consumed and nothing follows. Each table slot has a write-source selector with the values NONE, HOST, INSTALL and STATS, which applies host write over classifier install over counter update.

Top module: `flow_fastpath`

## Requirements
- R1: After reset every table slot is invalid, `hit_valid` and `miss_valid` are low and `in_ready` is high.
- R2: A record whose `in_key` equals the key of a valid slot at index `in_hash` leaves on the hit output with that slot's action code on `hit_action`, and with hash, key and length unchanged.
- R3: A record whose slot is invalid, or whose slot holds a different key, leaves on the miss output with hash, key and length unchanged. Hit and miss outputs are never valid together.
- R4: Each hit adds one to the slot's 32-bit packet counter and adds `in_len` to its 48-bit byte counter.
- R5: A host write (`host_we`) sets the slot's valid bit from `host_entry_en` and sets its key and action. It clears both counters. A slot written with `host_entry_en` = 0 gives misses.
- R6: A host read (`host_re`) returns the slot's valid bit, action and both counters on the next cycle with `host_rd_vld` high. Reads never lower `in_ready`.
- R7: A classifier install (`ins_valid`) makes the slot at `ins_hash` valid with the given key and action, overwriting any previous entry, and clears its counters. Later packets of that flow hit.
- R8: When an install and a hit's counter update target the same slot in one cycle, the install wins and the counters read zero. The in-flight record is judged against the slot contents from before the install.
- R9: When a host write and an install target the same slot in one cycle, the host write wins.
- R10: A record accepted at a clock edge is presented on its output after the following edge. With both outputs ready, one record is accepted every cycle. Back-to-back hits on the same flow are all counted.
- R11: A result whose output is not ready stays valid and stable. With both stages full, `in_ready` is low. Records leave in arrival order, and counters change only when a record enters the result stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Metadata record offered |
| in_ready | output | 1 | Record accepted this cycle when high with in_valid |
| in_hash | input | IDX_W | Header hash, used as table index |
| in_key | input | KEY_W | Flow key |
| in_len | input | LEN_W | Packet length in bytes |
| hit_valid | output | 1 | Hit result present |
| hit_ready | input | 1 | Hit consumer ready |
| hit_action | output | ACT_W | Stored action code |
| hit_hash | output | IDX_W | Hash of the hit record |
| hit_key | output | KEY_W | Key of the hit record |
| hit_len | output | LEN_W | Length of the hit record |
| miss_valid | output | 1 | Miss record present |
| miss_ready | input | 1 | Classifier ready |
| miss_hash | output | IDX_W | Hash of the missed record |
| miss_key | output | KEY_W | Key of the missed record |
| miss_len | output | LEN_W | Length of the missed record |
| ins_valid | input | 1 | Classifier install strobe |
| ins_hash | input | IDX_W | Slot to install |
| ins_key | input | KEY_W | Key to install |
| ins_action | input | ACT_W | Action to install |
| host_we | input | 1 | Host write strobe |
| host_addr | input | IDX_W | Host write slot |
| host_entry_en | input | 1 | Valid bit written by host |
| host_key | input | KEY_W | Key written by host |
| host_action | input | ACT_W | Action written by host |
| host_re | input | 1 | Host read strobe |
| host_rd_addr | input | IDX_W | Host read slot |
| host_rd_vld | output | 1 | Read data present (one cycle after host_re) |
| host_rd_entry_en | output | 1 | Valid bit of the read slot |
| host_rd_action | output | ACT_W | Action of the read slot |
| host_rd_pkts | output | PKT_W | Packet counter of the read slot |
| host_rd_bytes | output | BYTE_W | Byte counter of the read slot |

## Verification
A record accepted at edge k is visible on the hit or miss output after edge k+1. Its counter update lands at that same edge k+1, so a read requested at the next edge returns data after edge k+2. The bench drives inputs on falling edges and samples at the falling edge after the cycle in which each result is due. For lookups that is two rising edges after the offer, for host reads one rising edge after the request. In the back-to-back stream, each output is counted at the falling edge where it is valid, and the counter totals are read only after the last record has passed. In the stall test the held output and the low `in_ready` are sampled once both stages have filled, and counters are read while the stall persists.

// File: rtl/ft_pkg.sv
package ft_pkg;

    typedef enum logic {
        STG_EMPTY,
        STG_FULL
    } stg_st_e;

    typedef enum logic [1:0] {
        OUT_IDLE,
        OUT_HIT,
        OUT_MISS
    } out_st_e;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_HOST,
        WR_INSTALL,
        WR_STATS
    } wr_src_e;

endpackage

// File: rtl/ft_table.sv
module ft_table
    import ft_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int KEY_W  = 32,
    parameter int ACT_W  = 8,
    parameter int LEN_W  = 16,
    parameter int PKT_W  = 32,
    parameter int BYTE_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    // combinational lookup port
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_valid,
    output logic [KEY_W-1:0]  lk_key,
    output logic [ACT_W-1:0]  lk_act,
    // host write
    input  logic              hw_en,
    input  logic [IDX_W-1:0]  hw_idx,
    input  logic              hw_valid_bit,
    input  logic [KEY_W-1:0]  hw_key,
    input  logic [ACT_W-1:0]  hw_act,
    // classifier install
    input  logic              in_en,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [KEY_W-1:0]  in_key,
    input  logic [ACT_W-1:0]  in_act,
    // counter update
    input  logic              up_en,
    input  logic [IDX_W-1:0]  up_idx,
    input  logic [LEN_W-1:0]  up_len,
    // host read
    input  logic              hr_en,
    input  logic [IDX_W-1:0]  hr_idx,
    output logic              hr_vld,
    output logic              hr_valid_bit,
    output logic [ACT_W-1:0]  hr_act,
    output logic [PKT_W-1:0]  hr_pkts,
    output logic [BYTE_W-1:0] hr_bytes
);

    localparam int DEPTH = 1 << IDX_W;

    logic              val_arr  [DEPTH];
    logic [KEY_W-1:0]  key_arr  [DEPTH];
    logic [ACT_W-1:0]  act_arr  [DEPTH];
    logic [PKT_W-1:0]  pkt_arr  [DEPTH];
    logic [BYTE_W-1:0] byte_arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

        wr_src_e           sel;
        logic              v_r;
        logic [KEY_W-1:0]  k_r;
        logic [ACT_W-1:0]  a_r;
        logic [PKT_W-1:0]  p_r;
        logic [BYTE_W-1:0] b_r;

        // write-source priority: host, then install, then counters
        always_comb begin
            if (hw_en && hw_idx == MY_IDX)
                sel = WR_HOST;
            else if (in_en && in_idx == MY_IDX)
                sel = WR_INSTALL;
            else if (up_en && up_idx == MY_IDX)
                sel = WR_STATS;
            else
                sel = WR_NONE;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_r <= 1'b0;
                k_r <= '0;
                a_r <= '0;
                p_r <= '0;
                b_r <= '0;
            end else begin
                unique case (sel)
                    WR_NONE: ;
                    WR_HOST: begin
                        v_r <= hw_valid_bit;
                        k_r <= hw_key;
                        a_r <= hw_act;
                        p_r <= '0;
                        b_r <= '0;
                    end
                    WR_INSTALL: begin
                        v_r <= 1'b1;
                        k_r <= in_key;
                        a_r <= in_act;
                        p_r <= '0;
                        b_r <= '0;
                    end
                    WR_STATS: begin
                        p_r <= p_r + PKT_W'(1);
                        b_r <= b_r + BYTE_W'(up_len);
                    end
                endcase
            end
        end

        assign val_arr[g]  = v_r;
        assign key_arr[g]  = k_r;
        assign act_arr[g]  = a_r;
        assign pkt_arr[g]  = p_r;
        assign byte_arr[g] = b_r;
    end

    assign lk_valid = val_arr[lk_idx];
    assign lk_key   = key_arr[lk_idx];
    assign lk_act   = act_arr[lk_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hr_vld       <= 1'b0;
            hr_valid_bit <= 1'b0;
            hr_act       <= '0;
            hr_pkts      <= '0;
            hr_bytes     <= '0;
        end else begin
            hr_vld <= hr_en;
            if (hr_en) begin
                hr_valid_bit <= val_arr[hr_idx];
                hr_act       <= act_arr[hr_idx];
                hr_pkts      <= pkt_arr[hr_idx];
                hr_bytes     <= byte_arr[hr_idx];
            end
        end
    end

    // R4: an unopposed update steps the packet counter by one
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && !(hw_en && hw_idx == up_idx) && !(in_en && in_idx == up_idx))
        |=> pkt_arr[$past(up_idx)] == $past(pkt_arr[up_idx]) + PKT_W'(1));

    // R7, R8: an install not overridden by the host leaves a valid, zeroed slot
    a_r8_install_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (in_en && !(hw_en && hw_idx == in_idx))
        |=> val_arr[$past(in_idx)] && pkt_arr[$past(in_idx)] == '0
            && act_arr[$past(in_idx)] == $past(in_act));

    // R9: a host write always lands
    a_r9_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hw_en |=> act_arr[$past(hw_idx)] == $past(hw_act)
                  && byte_arr[$past(hw_idx)] == '0);

endmodule

// File: rtl/ft_stage_in.sv
module ft_stage_in
    import ft_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int KEY_W = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IDX_W-1:0] in_hash,
    input  logic [KEY_W-1:0] in_key,
    input  logic [LEN_W-1:0] in_len,
    input  logic             adv,
    output logic             a_full,
    output logic [IDX_W-1:0] a_hash,
    output logic [KEY_W-1:0] a_key,
    output logic [LEN_W-1:0] a_len
);

    stg_st_e st_q, st_d;
    logic    load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= STG_EMPTY;
        else
            st_q <= st_d;
    end

    // transitions: load (EMPTY->FULL), refill (FULL->FULL), drain (FULL->EMPTY)
    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q)
            STG_EMPTY: begin
                if (in_valid) begin
                    st_d = STG_FULL;
                    load = 1'b1;
                end
            end
            STG_FULL: begin
                if (adv) begin
                    load = in_valid;
                    st_d = in_valid ? STG_FULL : STG_EMPTY;
                end
            end
        endcase
    end

    always_comb begin
        unique case (st_q)
            STG_EMPTY: begin
                in_ready = 1'b1;
                a_full   = 1'b0;
            end
            STG_FULL: begin
                in_ready = adv;
                a_full   = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_hash <= '0;
            a_key  <= '0;
            a_len  <= '0;
        end else if (load) begin
            a_hash <= in_hash;
            a_key  <= in_key;
            a_len  <= in_len;
        end
    end

    // R11: a held record stays put until the result stage takes it
    a_r11_hold_input: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == STG_FULL && !adv)
        |=> st_q == STG_FULL && $stable(a_key) && $stable(a_hash) && $stable(a_len));

endmodule

// File: rtl/ft_stage_out.sv
module ft_stage_out
    import ft_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int KEY_W = 32,
    parameter int ACT_W = 8,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_full,
    input  logic [IDX_W-1:0] a_hash,
    input  logic [KEY_W-1:0] a_key,
    input  logic [LEN_W-1:0] a_len,
    input  logic             t_valid,
    input  logic [KEY_W-1:0] t_key,
    input  logic [ACT_W-1:0] t_act,
    input  logic             hit_ready,
    input  logic             miss_ready,
    output logic             adv,
    output logic             upd_en,
    output logic             hit_valid,
    output logic             miss_valid,
    output logic [IDX_W-1:0] o_hash,
    output logic [KEY_W-1:0] o_key,
    output logic [LEN_W-1:0] o_len,
    output logic [ACT_W-1:0] o_act
);

    out_st_e st_q, st_d;
    logic    b_free;
    logic    is_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= OUT_IDLE;
        else
            st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            OUT_IDLE: b_free = 1'b1;
            OUT_HIT:  b_free = hit_ready;
            OUT_MISS: b_free = miss_ready;
            default:  b_free = 1'b0;
        endcase
        adv    = a_full && b_free;
        is_hit = t_valid && (t_key == a_key);
        upd_en = adv && is_hit;
        if (adv)
            st_d = is_hit ? OUT_HIT : OUT_MISS;
        else if (b_free)
            st_d = OUT_IDLE;
        else
            st_d = st_q;
    end

    always_comb begin
        unique case (st_q)
            OUT_HIT: begin
                hit_valid  = 1'b1;
                miss_valid = 1'b0;
            end
            OUT_MISS: begin
                hit_valid  = 1'b0;
                miss_valid = 1'b1;
            end
            default: begin
                hit_valid  = 1'b0;
                miss_valid = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_hash <= '0;
            o_key  <= '0;
            o_len  <= '0;
            o_act  <= '0;
        end else if (adv) begin
            o_hash <= a_hash;
            o_key  <= a_key;
            o_len  <= a_len;
            o_act  <= is_hit ? t_act : '0;
        end
    end

    // R11: stalled hit result is held
    a_r11_hold_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !hit_ready)
        |=> hit_valid && $stable(o_key) && $stable(o_act) && $stable(o_len));

    // R11: stalled miss result is held
    a_r11_hold_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !miss_ready)
        |=> miss_valid && $stable(o_key) && $stable(o_hash) && $stable(o_len));

endmodule

// File: rtl/flow_fastpath.sv
module flow_fastpath
    import ft_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int KEY_W  = 32,
    parameter int ACT_W  = 8,
    parameter int LEN_W  = 16,
    parameter int PKT_W  = 32,
    parameter int BYTE_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_hash,
    input  logic [KEY_W-1:0]  in_key,
    input  logic [LEN_W-1:0]  in_len,
    output logic              hit_valid,
    input  logic              hit_ready,
    output logic [ACT_W-1:0]  hit_action,
    output logic [IDX_W-1:0]  hit_hash,
    output logic [KEY_W-1:0]  hit_key,
    output logic [LEN_W-1:0]  hit_len,
    output logic              miss_valid,
    input  logic              miss_ready,
    output logic [IDX_W-1:0]  miss_hash,
    output logic [KEY_W-1:0]  miss_key,
    output logic [LEN_W-1:0]  miss_len,
    input  logic              ins_valid,
    input  logic [IDX_W-1:0]  ins_hash,
    input  logic [KEY_W-1:0]  ins_key,
    input  logic [ACT_W-1:0]  ins_action,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic              host_entry_en,
    input  logic [KEY_W-1:0]  host_key,
    input  logic [ACT_W-1:0]  host_action,
    input  logic              host_re,
    input  logic [IDX_W-1:0]  host_rd_addr,
    output logic              host_rd_vld,
    output logic              host_rd_entry_en,
    output logic [ACT_W-1:0]  host_rd_action,
    output logic [PKT_W-1:0]  host_rd_pkts,
    output logic [BYTE_W-1:0] host_rd_bytes
);

    logic             a_full, adv, upd_en;
    logic [IDX_W-1:0] a_hash, o_hash;
    logic [KEY_W-1:0] a_key, o_key, t_key;
    logic [LEN_W-1:0] a_len, o_len;
    logic [ACT_W-1:0] t_act, o_act;
    logic             t_valid;

    ft_stage_in #(.IDX_W(IDX_W), .KEY_W(KEY_W), .LEN_W(LEN_W)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_hash  (in_hash),
        .in_key   (in_key),
        .in_len   (in_len),
        .adv      (adv),
        .a_full   (a_full),
        .a_hash   (a_hash),
        .a_key    (a_key),
        .a_len    (a_len)
    );

    ft_table #(
        .IDX_W(IDX_W), .KEY_W(KEY_W), .ACT_W(ACT_W),
        .LEN_W(LEN_W), .PKT_W(PKT_W), .BYTE_W(BYTE_W)
    ) u_tab (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_idx       (a_hash),
        .lk_valid     (t_valid),
        .lk_key       (t_key),
        .lk_act       (t_act),
        .hw_en        (host_we),
        .hw_idx       (host_addr),
        .hw_valid_bit (host_entry_en),
        .hw_key       (host_key),
        .hw_act       (host_action),
        .in_en        (ins_valid),
        .in_idx       (ins_hash),
        .in_key       (ins_key),
        .in_act       (ins_action),
        .up_en        (upd_en),
        .up_idx       (a_hash),
        .up_len       (a_len),
        .hr_en        (host_re),
        .hr_idx       (host_rd_addr),
        .hr_vld       (host_rd_vld),
        .hr_valid_bit (host_rd_entry_en),
        .hr_act       (host_rd_action),
        .hr_pkts      (host_rd_pkts),
        .hr_bytes     (host_rd_bytes)
    );

    ft_stage_out #(.IDX_W(IDX_W), .KEY_W(KEY_W), .ACT_W(ACT_W), .LEN_W(LEN_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .a_full     (a_full),
        .a_hash     (a_hash),
        .a_key      (a_key),
        .a_len      (a_len),
        .t_valid    (t_valid),
        .t_key      (t_key),
        .t_act      (t_act),
        .hit_ready  (hit_ready),
        .miss_ready (miss_ready),
        .adv        (adv),
        .upd_en     (upd_en),
        .hit_valid  (hit_valid),
        .miss_valid (miss_valid),
        .o_hash     (o_hash),
        .o_key      (o_key),
        .o_len      (o_len),
        .o_act      (o_act)
    );

    assign hit_action = o_act;
    assign hit_hash   = o_hash;
    assign hit_key    = o_key;
    assign hit_len    = o_len;
    assign miss_hash  = o_hash;
    assign miss_key   = o_key;
    assign miss_len   = o_len;

    // R3: one record is never reported on both outputs
    a_r3_one_output: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_valid && miss_valid));

endmodule

// File: tb/sim_flow_fastpath.sv
module sim_flow_fastpath;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_hash = '0;
    logic [31:0] in_key = '0;
    logic [15:0] in_len = '0;
    logic        hit_valid;
    logic        hit_ready = 1'b1;
    logic [7:0]  hit_action;
    logic [7:0]  hit_hash;
    logic [31:0] hit_key;
    logic [15:0] hit_len;
    logic        miss_valid;
    logic        miss_ready = 1'b1;
    logic [7:0]  miss_hash;
    logic [31:0] miss_key;
    logic [15:0] miss_len;
    logic        ins_valid = 1'b0;
    logic [7:0]  ins_hash = '0;
    logic [31:0] ins_key = '0;
    logic [7:0]  ins_action = '0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic        host_entry_en = 1'b0;
    logic [31:0] host_key = '0;
    logic [7:0]  host_action = '0;
    logic        host_re = 1'b0;
    logic [7:0]  host_rd_addr = '0;
    logic        host_rd_vld;
    logic        host_rd_entry_en;
    logic [7:0]  host_rd_action;
    logic [31:0] host_rd_pkts;
    logic [47:0] host_rd_bytes;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    flow_fastpath u0 (.*);

    typedef struct packed {
        logic [7:0]  h;
        logic [31:0] k;
        logic [15:0] len;
        logic        hit;
        logic [7:0]  act;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'd5, 32'hA0A0_0005, 16'd100, 1'b1, 8'h11},
        '{8'd5, 32'hC0C0_0005, 16'd60,  1'b0, 8'h00},
        '{8'd7, 32'hD0D0_0007, 16'd10,  1'b0, 8'h00},
        '{8'd9, 32'hB0B0_0009, 16'd64,  1'b1, 8'h22},
        '{8'd5, 32'hA0A0_0005, 16'd40,  1'b1, 8'h11}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [7:0] h, input logic [31:0] k, input logic [15:0] len,
                          input logic exp_hit, input logic [7:0] exp_act, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_hash = h; in_key = k; in_len = len;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk({req, " hit_valid"}, 64'(hit_valid), 64'(exp_hit));
        chk({req, " miss_valid"}, 64'(miss_valid), 64'(!exp_hit));
        if (exp_hit) begin
            chk({req, " hit_action"}, 64'(hit_action), 64'(exp_act));
            chk({req, " hit_key"}, 64'(hit_key), 64'(k));
            chk({req, " hit_len"}, 64'(hit_len), 64'(len));
        end else begin
            chk({req, " miss_key"}, 64'(miss_key), 64'(k));
            chk({req, " miss_hash"}, 64'(miss_hash), 64'(h));
            chk({req, " miss_len"}, 64'(miss_len), 64'(len));
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] k, input logic [7:0] act,
                          input logic en);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_key = k; host_action = act; host_entry_en = en;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic install(input logic [7:0] h, input logic [31:0] k, input logic [7:0] act);
        @(negedge clk);
        ins_valid = 1'b1; ins_hash = h; ins_key = k; ins_action = act;
        @(posedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, input logic exp_en, input logic [7:0] exp_act,
                         input logic [31:0] exp_p, input logic [47:0] exp_b, input string req);
        @(negedge clk);
        host_re = 1'b1; host_rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        host_re = 1'b0;
        chk({req, " rd_vld"}, 64'(host_rd_vld), 64'd1);
        chk({req, " rd_entry_en"}, 64'(host_rd_entry_en), 64'(exp_en));
        if (exp_en) begin
            chk({req, " rd_action"}, 64'(host_rd_action), 64'(exp_act));
            chk({req, " rd_pkts"}, 64'(host_rd_pkts), 64'(exp_p));
            chk({req, " rd_bytes"}, 64'(host_rd_bytes), 64'(exp_b));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 in_ready", 64'(in_ready), 64'd1);
        chk("R1 hit_valid", 64'(hit_valid), 64'd0);
        chk("R1 miss_valid", 64'(miss_valid), 64'd0);
        hread(8'd5, 1'b0, 8'h00, 32'd0, 48'd0, "R1 slot5 invalid");

        // R5: host preload
        hwrite(8'd5, 32'hA0A0_0005, 8'h11, 1'b1);
        hwrite(8'd9, 32'hB0B0_0009, 8'h22, 1'b1);

        // R2, R3: vector table walk
        for (int i = 0; i < 5; i++)
            lookup(VECS[i].h, VECS[i].k, VECS[i].len, VECS[i].hit, VECS[i].act,
                   VECS[i].hit ? "R2 vector hit" : "R3 vector miss");

        // R4: counters after the vector walk
        hread(8'd5, 1'b1, 8'h11, 32'd2, 48'd140, "R4 slot5 stats");
        hread(8'd9, 1'b1, 8'h22, 32'd1, 48'd64, "R4 slot9 stats");

        // R7: classifier install turns a miss into a hit
        install(8'd7, 32'hD0D0_0007, 8'h33);
        lookup(8'd7, 32'hD0D0_0007, 16'd10, 1'b1, 8'h33, "R7 installed flow hits");
        hread(8'd7, 1'b1, 8'h33, 32'd1, 48'd10, "R7 slot7 stats");

        // R10, R6: back-to-back stream on one flow, host reads alongside
        begin
            int hits = 0;
            int sum  = 0;
            for (int cyc = 0; cyc < 8; cyc++) begin
                @(negedge clk);
                if (hit_valid) begin
                    hits++;
                    sum += int'(hit_len);
                    chk("R10 stream action", 64'(hit_action), 64'h33);
                end
                chk("R6 read does not stall", 64'(in_ready), 64'd1);
                in_valid = (cyc < 4);
                in_hash = 8'd7; in_key = 32'hD0D0_0007; in_len = 16'(cyc + 1);
                host_re = cyc[0]; host_rd_addr = 8'd7;
            end
            in_valid = 1'b0;
            host_re = 1'b0;
            chk("R10 stream hit count", 64'(hits), 64'd4);
            chk("R10 stream length sum", 64'(sum), 64'd10);
        end
        hread(8'd7, 1'b1, 8'h33, 32'd5, 48'd20, "R10 slot7 stats after stream");

        // R7: overwrite at an occupied index clears counters
        install(8'd5, 32'hC0C0_0005, 8'h44);
        hread(8'd5, 1'b1, 8'h44, 32'd0, 48'd0, "R7 overwrite clears");
        lookup(8'd5, 32'hA0A0_0005, 16'd4, 1'b0, 8'h00, "R7 old key now misses");
        lookup(8'd5, 32'hC0C0_0005, 16'd8, 1'b1, 8'h44, "R7 new key hits");

        // R5: host rewrite clears counters; disabled slot misses
        hwrite(8'd5, 32'hC0C0_0005, 8'h45, 1'b1);
        hread(8'd5, 1'b1, 8'h45, 32'd0, 48'd0, "R5 host rewrite clears");
        hwrite(8'd5, 32'hC0C0_0005, 8'h45, 1'b0);
        lookup(8'd5, 32'hC0C0_0005, 16'd8, 1'b0, 8'h00, "R5 disabled slot misses");

        // R8: install coinciding with a hit's counter update
        @(negedge clk);
        in_valid = 1'b1; in_hash = 8'd9; in_key = 32'hB0B0_0009; in_len = 16'd64;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        ins_valid = 1'b1; ins_hash = 8'd9; ins_key = 32'hE0E0_0009; ins_action = 8'h55;
        @(posedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
        chk("R8 in-flight hit uses old entry", 64'(hit_valid), 64'd1);
        chk("R8 in-flight action", 64'(hit_action), 64'h22);
        hread(8'd9, 1'b1, 8'h55, 32'd0, 48'd0, "R8 install wins");

        // R9: host write against install, same slot, same cycle
        @(negedge clk);
        host_we = 1'b1; host_addr = 8'd20; host_key = 32'hF0F0_0014;
        host_action = 8'h66; host_entry_en = 1'b1;
        ins_valid = 1'b1; ins_hash = 8'd20; ins_key = 32'h7070_0014; ins_action = 8'h77;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0; ins_valid = 1'b0;
        hread(8'd20, 1'b1, 8'h66, 32'd0, 48'd0, "R9 host wins");
        lookup(8'd20, 32'hF0F0_0014, 16'd3, 1'b1, 8'h66, "R9 host key hits");

        // R11: back-pressure on the hit output
        @(negedge clk);
        hit_ready = 1'b0;
        in_valid = 1'b1; in_hash = 8'd9; in_key = 32'hE0E0_0009; in_len = 16'd5;
        @(posedge clk);
        @(negedge clk);
        in_len = 16'd6;
        @(posedge clk);
        @(negedge clk);
        in_len = 16'd7;
        chk("R11 in_ready low when full", 64'(in_ready), 64'd0);
        chk("R11 first result valid", 64'(hit_valid), 64'd1);
        chk("R11 first result len", 64'(hit_len), 64'd5);
        in_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R11 held len", 64'(hit_len), 64'd5);
        end
        hread(8'd9, 1'b1, 8'h55, 32'd1, 48'd5, "R11 counts only advanced record");
        @(negedge clk);
        hit_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R11 second in order valid", 64'(hit_valid), 64'd1);
        chk("R11 second in order len", 64'(hit_len), 64'd6);
        @(posedge clk);
        @(negedge clk);
        chk("R11 drained", 64'(hit_valid), 64'd0);
        hread(8'd9, 1'b1, 8'h55, 32'd2, 48'd11, "R11 final stats");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule